// File: doc/BRIEF.md
# Table Entry Watch Window

This block gives a register bus access to one entry of a table that lives in memory. Software first writes a selector register with a block number and an entry offset. The block turns that pair into a memory address. The entry's 64-bit words then appear in a row of data registers.

Reading the first data register fetches the entire entry from memory. Writing the first data register pushes the entire entry back to memory. Every other data register is plain storage, so software fills words 1 and up first and writes word 0 last to commit the entry.

The bus side uses a valid/ready handshake. `bus_ready` stays low while a multi-word fetch or commit is running. The memory side moves one word per request/acknowledge pair. Words are big-endian in memory and in native order in the registers. An error flag reports an entry that could not be fetched or does not exist.

Top module: `entry_watch_window`

## Requirements
- R1: After reset the selector reads 0, every data register reads 0, `load_err` is low and `mem_req` is low.
- R2: A read of register index 8 (data word 0) holds `bus_ready` low until all NWORDS words have been fetched, then returns the fetched word 0. With a memory that acknowledges every second cycle, ready appears 2*NWORDS+1 cycles after the request.
- R3: Reads of data words 1 to NWORDS-1 (indices 9 upward) return the held value and make no memory request.
- R4: A write to index 8 stores the value in word 0, then writes words 0 to NWORDS-1 to memory in ascending address order, one memory write per word.
- R5: Writes to data words 1 to NWORDS-1 only update the register and make no memory request.
- R6: The selector (index 0) holds the entry offset in bits [OFF_W-1:0] and the block number in bits [32+BLK_W-1:32]. On a write, bit 63 is cleared before storing. A read always returns bits 63 and 62 as 0.
- R7: Writes to index 2 and index 3 are accepted at once and change no register and no memory word.
- R8: Each register word equals its memory word with the eight bytes reversed, in both directions.
- R9: If any word of a fetch comes back with `mem_rerr`, every data register is 0 when the read completes and `load_err` is set.
- R10: The address of word k is `tbl_base + block*blk_stride + offset*NWORDS*8 + 8*k`.
- R11: A block number of NUM_BLOCKS or more sets `load_err` and makes no memory request. On a read the data registers become 0. On a write, only word 0 is updated.
- R12: `load_err` clears when a later access to index 8 selects an existing entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_idx | input | 4 | Register index |
| bus_wdata | input | 64 | Write data |
| bus_ready | output | 1 | Access completes in this cycle |
| bus_rdata | output | 64 | Read data, valid while bus_ready is high |
| tbl_base | input | AW | Table byte base address |
| blk_stride | input | AW | Byte distance between blocks |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory byte address |
| mem_wdata | output | 64 | Memory write word (big-endian) |
| mem_ack | input | 1 | Memory acknowledge for the current word |
| mem_rdata | input | 64 | Memory read word, valid with mem_ack |
| mem_rerr | input | 1 | Read failed, valid with mem_ack |
| load_err | output | 1 | Fetch or selection error flag |

## Verification
The assertions assume a bus master that keeps `bus_valid`, `bus_write` and `bus_idx` steady until it sees `bus_ready`. They also assume a memory that acknowledges only while `mem_req` is high. The bench drives each access from a task that holds all request fields until ready, then drops valid. Its memory model acknowledges every other requested cycle and never acknowledges without a request. The selector is changed only between accesses, so no transfer sees it move.

// File: rtl/entry_watch_pkg.sv
package entry_watch_pkg;

    localparam int WORD_W = 64;
    localparam int IDX_W  = 4;

    localparam logic [IDX_W-1:0] IDX_SEL        = 4'd0;
    localparam logic [IDX_W-1:0] IDX_SCRUB_MASK = 4'd2;
    localparam logic [IDX_W-1:0] IDX_SCRUB_TRIG = 4'd3;
    localparam logic [IDX_W-1:0] IDX_DATA0      = 4'd8;

    localparam int SEL_BLK_LSB = 32;

    localparam logic [WORD_W-1:0] SEL_CONFLICT = 64'h8000_0000_0000_0000;
    localparam logic [WORD_W-1:0] SEL_STATUS   = 64'hC000_0000_0000_0000;

    typedef enum logic [1:0] {
        XS_IDLE,
        XS_LOAD,
        XS_STORE,
        XS_DONE
    } xfer_state_e;

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [IDX_W-1:0] idx;
    } bus_cmd_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] r;
        for (int b = 0; b < 8; b++) begin
            r[8*b +: 8] = w[8*(7-b) +: 8];
        end
        return r;
    endfunction

endpackage

// File: rtl/ew_addr_gen.sv
module ew_addr_gen
    import entry_watch_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BLK_W      = 4,
    parameter int OFF_W      = 8,
    parameter int NUM_BLOCKS = 4,
    parameter int NWORDS     = 4
) (
    input  logic [BLK_W-1:0] blk,
    input  logic [OFF_W-1:0] off,
    input  logic [AW-1:0]    base,
    input  logic [AW-1:0]    stride,
    output logic [AW-1:0]    entry_addr,
    output logic             entry_ok
);
    localparam int ENTRY_SHIFT = $clog2(NWORDS) + 3;

    logic [AW-1:0] blk_part;
    logic [AW-1:0] off_part;

    always_comb begin
        blk_part   = AW'(blk) * stride;
        off_part   = AW'(off) << ENTRY_SHIFT;
        entry_addr = base + blk_part + off_part;
        entry_ok   = int'(blk) < NUM_BLOCKS;
    end

endmodule

// File: rtl/ew_xfer_ctrl.sv
module ew_xfer_ctrl
    import entry_watch_pkg::*;
#(
    parameter int AW     = 32,
    parameter int NWORDS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_cmd_t          cmd,
    input  logic [AW-1:0]     entry_addr,
    input  logic              entry_ok,
    input  logic [WORD_W-1:0] store_word,
    output logic              bus_ready,
    output logic [$clog2(NWORDS)-1:0] word_idx,
    output logic              ld_we,
    output logic [WORD_W-1:0] ld_word,
    output logic              zero_all,
    output logic              err_set,
    output logic              err_clr,
    output logic              d0_latch,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_rerr
);
    localparam int CW = $clog2(NWORDS);

    xfer_state_e   state;
    logic [CW-1:0] cnt;
    logic          fail_q;
    logic [AW-1:0] addr_q;
    logic          is_d0, start, last, load_bad;

    always_comb begin
        is_d0     = cmd.valid && (cmd.idx == IDX_DATA0);
        start     = (state == XS_IDLE) && is_d0;
        last      = cnt == CW'(NWORDS - 1);
        bus_ready = ((state == XS_IDLE) && !is_d0) || (state == XS_DONE);
        load_bad  = (state == XS_LOAD) && mem_ack && last && (fail_q || mem_rerr);
        d0_latch  = start && cmd.write;
        err_clr   = start && entry_ok;
        err_set   = (start && !entry_ok) || load_bad;
        zero_all  = (start && !entry_ok && !cmd.write) || load_bad;
        ld_we     = (state == XS_LOAD) && mem_ack;
        ld_word   = mem_rerr ? '0 : swap_bytes(mem_rdata);
        word_idx  = cnt;
        mem_req   = (state == XS_LOAD) || (state == XS_STORE);
        mem_we    = state == XS_STORE;
        mem_addr  = addr_q + (AW'(cnt) << 3);
        mem_wdata = swap_bytes(store_word);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= XS_IDLE;
            cnt    <= '0;
            fail_q <= 1'b0;
            addr_q <= '0;
        end else begin
            case (state)
                XS_IDLE: if (start) begin
                    cnt    <= '0;
                    fail_q <= 1'b0;
                    addr_q <= entry_addr;
                    if (!entry_ok)      state <= XS_DONE;
                    else if (cmd.write) state <= XS_STORE;
                    else                state <= XS_LOAD;
                end
                XS_LOAD: if (mem_ack) begin
                    fail_q <= fail_q | mem_rerr;
                    if (last) state <= XS_DONE;
                    else      cnt   <= cnt + 1'b1;
                end
                XS_STORE: if (mem_ack) begin
                    if (last) state <= XS_DONE;
                    else      cnt   <= cnt + 1'b1;
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    assert_busy_stall_R2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !bus_ready);

    assert_load_readonly_R3: assert property (@(posedge clk) disable iff (rst)
        (mem_req && cmd.valid && !cmd.write) |-> !mem_we);

    assert_hold_addr_R10: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_word_step_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req && mem_ack)) |-> (mem_addr == $past(mem_addr) + AW'(8)));

endmodule

// File: rtl/entry_watch_window.sv
module entry_watch_window
    import entry_watch_pkg::*;
#(
    parameter int AW         = 32,
    parameter int BLK_W      = 4,
    parameter int OFF_W      = 8,
    parameter int NUM_BLOCKS = 4,
    parameter int NWORDS     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [3:0]        bus_idx,
    input  logic [63:0]       bus_wdata,
    output logic              bus_ready,
    output logic [63:0]       bus_rdata,
    input  logic [AW-1:0]     tbl_base,
    input  logic [AW-1:0]     blk_stride,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [63:0]       mem_wdata,
    input  logic              mem_ack,
    input  logic [63:0]       mem_rdata,
    input  logic              mem_rerr,
    output logic              load_err
);
    localparam int CW = $clog2(NWORDS);

    bus_cmd_t          cmd;
    logic [WORD_W-1:0] sel_q;
    logic [WORD_W-1:0] data_q [NWORDS];
    logic              err_q;
    logic [AW-1:0]     entry_addr;
    logic              entry_ok;
    logic [CW-1:0]     word_idx;
    logic              ld_we, zero_all, err_set, err_clr, d0_latch;
    logic [WORD_W-1:0] ld_word;
    logic              wr_acc;
    logic [IDX_W-1:0]  didx;
    logic              tail_wr;

    always_comb begin
        cmd.valid = bus_valid;
        cmd.write = bus_write;
        cmd.idx   = bus_idx;
        wr_acc    = bus_valid && bus_write && bus_ready && (bus_idx != IDX_DATA0);
        didx      = bus_idx - IDX_DATA0;
        tail_wr   = wr_acc && (bus_idx > IDX_DATA0) && (int'(didx) < NWORDS);
    end

    ew_addr_gen #(
        .AW(AW), .BLK_W(BLK_W), .OFF_W(OFF_W),
        .NUM_BLOCKS(NUM_BLOCKS), .NWORDS(NWORDS)
    ) u_addr (
        .blk        (sel_q[SEL_BLK_LSB +: BLK_W]),
        .off        (sel_q[OFF_W-1:0]),
        .base       (tbl_base),
        .stride     (blk_stride),
        .entry_addr (entry_addr),
        .entry_ok   (entry_ok)
    );

    ew_xfer_ctrl #(.AW(AW), .NWORDS(NWORDS)) u_xfer (
        .clk        (clk),
        .rst        (rst),
        .cmd        (cmd),
        .entry_addr (entry_addr),
        .entry_ok   (entry_ok),
        .store_word (data_q[word_idx]),
        .bus_ready  (bus_ready),
        .word_idx   (word_idx),
        .ld_we      (ld_we),
        .ld_word    (ld_word),
        .zero_all   (zero_all),
        .err_set    (err_set),
        .err_clr    (err_clr),
        .d0_latch   (d0_latch),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .mem_rerr   (mem_rerr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            err_q <= 1'b0;
        end else begin
            if (wr_acc && bus_idx == IDX_SEL) sel_q <= bus_wdata & ~SEL_CONFLICT;
            if (err_set)      err_q <= 1'b1;
            else if (err_clr) err_q <= 1'b0;
        end
    end

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst || zero_all)                         data_q[i] <= '0;
            else if (ld_we && word_idx == CW'(i))        data_q[i] <= ld_word;
            else if (i == 0 && d0_latch)                 data_q[i] <= bus_wdata;
            else if (wr_acc && bus_idx == IDX_DATA0 + IDX_W'(i)) data_q[i] <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_idx == IDX_SEL) bus_rdata = sel_q & ~SEL_STATUS;
        else if (bus_idx >= IDX_DATA0 && int'(didx) < NWORDS) bus_rdata = data_q[didx[CW-1:0]];
        load_err = err_q;
    end

    assert_tail_latch_only_R5: assert property (@(posedge clk) disable iff (rst)
        tail_wr |=> !mem_req);

    assert_fail_zeroes_R9: assert property (@(posedge clk) disable iff (rst)
        zero_all |=> (data_q[0] == '0 && load_err));

endmodule

// File: tb/entry_watch_window_bench.sv
module entry_watch_window_bench;
    localparam int CLK_P  = 10;
    localparam int NW     = 4;
    localparam int AW     = 32;
    localparam logic [31:0] BASE   = 32'h100;
    localparam logic [31:0] STRIDE = 32'h200;
    localparam int NVEC = 6;
    // selection vectors: {block[3:0], offset[7:0]}
    localparam logic [11:0] VEC [NVEC] = '{12'h000, 12'h102, 12'h303, 12'h201, 12'h003, 12'h300};

    logic clk = 0, rst = 1;
    logic bus_valid = 0, bus_write = 0;
    logic [3:0] bus_idx = 0;
    logic [63:0] bus_wdata = 0;
    logic bus_ready, load_err;
    logic [63:0] bus_rdata;
    logic mem_req, mem_we, mem_ack, mem_rerr;
    logic [AW-1:0] mem_addr;
    logic [63:0] mem_wdata, mem_rdata;
    logic [63:0] mem [256];
    logic [7:0] midx;
    logic err_en = 0;
    logic [7:0] err_idx = 0;
    int wr_cnt, acc_cnt, n_chk, n_fail;
    bit done;

    always #(CLK_P/2) clk = ~clk;

    entry_watch_window #(.AW(AW), .NWORDS(NW)) u_entry_watch_window (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_idx(bus_idx), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata), .tbl_base(BASE), .blk_stride(STRIDE),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_rerr(mem_rerr), .load_err(load_err));

    function automatic logic [63:0] memval(input int i);
        return {16'(i) + 16'h1000, 16'hBEEF, 16'(i) ^ 16'h5A5A, 16'h0F0F + 16'(i)};
    endfunction

    function automatic logic [63:0] rev8(input logic [63:0] w);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[63-8*b -: 8] = w[8*b +: 8];
        return r;
    endfunction

    function automatic int word_of(input int blk, input int off, input int k);
        return (int'(BASE) + blk * int'(STRIDE) + off * NW * 8) / 8 + k;
    endfunction

    assign midx      = mem_addr[10:3];
    assign mem_rdata = mem[midx];
    assign mem_rerr  = mem_ack && err_en && (midx == err_idx);

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 0;
            wr_cnt  <= 0;
            acc_cnt <= 0;
            for (int i = 0; i < 256; i++) mem[i] <= memval(i);
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && mem_ack) begin
                acc_cnt <= acc_cnt + 1;
                if (mem_we) begin
                    mem[midx] <= mem_wdata;
                    wr_cnt <= wr_cnt + 1;
                end
            end
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [3:0] idx, input logic [63:0] wd,
                          output logic [63:0] rd, output int waits);
        bus_valid = 1; bus_write = wr; bus_idx = idx; bus_wdata = wd;
        waits = 0;
        #1;
        while (!bus_ready && waits < 1000) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = bus_rdata;
        @(negedge clk);
        bus_valid = 0;
    endtask

    task automatic wr(input logic [3:0] idx, input logic [63:0] wd);
        logic [63:0] d; int w;
        access(1'b1, idx, wd, d, w);
    endtask

    task automatic rdv(input logic [3:0] idx, output logic [63:0] d, output int w);
        access(1'b0, idx, 64'h0, d, w);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [63:0] d;
        int w, base_acc, base_wr, e;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1: reset state
        chk("R1 load_err", 64'(load_err), 64'h0);
        chk("R1 mem_req", 64'(mem_req), 64'h0);
        rdv(4'd0, d, w);  chk("R1 selector", d, 64'h0);
        rdv(4'd9, d, w);  chk("R1 data1", d, 64'h0);

        // Vector table: R2 R3 R8 R10
        for (int v = 0; v < NVEC; v++) begin
            int b, o;
            b = int'(VEC[v][11:8]); o = int'(VEC[v][7:0]);
            wr(4'd0, {24'h0, 8'(b), 24'h0, 8'(o)});
            base_wr = wr_cnt;
            rdv(4'd8, d, w);
            chk("R2 R8 R10 word0", d, rev8(memval(word_of(b, o, 0))));
            if (v == 0) chk("R2 ready latency", 64'(w), 64'(2 * NW + 1));
            base_acc = acc_cnt;
            for (int k = 1; k < NW; k++) begin
                rdv(4'(8 + k), d, w);
                chk("R3 R8 R10 tail word", d, rev8(memval(word_of(b, o, k))));
            end
            chk("R3 no memory access on tail read", 64'(acc_cnt), 64'(base_acc));
            chk("R2 load makes no write", 64'(wr_cnt), 64'(base_wr));
        end

        // R6: selector status bits
        wr(4'd0, 64'hC000_0001_0000_0001);
        rdv(4'd0, d, w);
        chk("R6 selector readback", d, 64'h0000_0001_0000_0001);

        // R5: tail writes only latch
        base_acc = acc_cnt;
        for (int k = 1; k < NW; k++) wr(4'(8 + k), 64'h1111_2222_3333_0000 + 64'(k));
        chk("R5 no memory access", 64'(acc_cnt), 64'(base_acc));
        rdv(4'd10, d, w);
        chk("R5 tail latched", d, 64'h1111_2222_3333_0002);

        // R4 R8: commit
        base_wr = wr_cnt;
        wr(4'd8, 64'h0102_0304_0506_0708);
        chk("R4 write count", 64'(wr_cnt - base_wr), 64'(NW));
        chk("R4 R8 word0 in memory", mem[word_of(1, 1, 0)], 64'h0807_0605_0403_0201);
        for (int k = 1; k < NW; k++)
            chk("R4 R8 tail in memory", mem[word_of(1, 1, k)], rev8(64'h1111_2222_3333_0000 + 64'(k)));
        rdv(4'd8, d, w);
        chk("R4 round trip", d, 64'h0102_0304_0506_0708);

        // R7: scrub registers
        base_acc = acc_cnt;
        wr(4'd2, 64'hFFFF_FFFF_FFFF_FFFF);
        wr(4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R7 no memory access", 64'(acc_cnt), 64'(base_acc));
        rdv(4'd9, d, w);  chk("R7 data unchanged", d, 64'h1111_2222_3333_0001);
        rdv(4'd0, d, w);  chk("R7 selector unchanged", d, 64'h0000_0001_0000_0001);

        // R9: fetch error
        wr(4'd0, 64'h0000_0002_0000_0002);
        err_en = 1; err_idx = 8'(word_of(2, 2, 2));
        rdv(4'd8, d, w);
        chk("R9 word0 zero", d, 64'h0);
        chk("R9 error flag", 64'(load_err), 64'h1);
        for (int k = 1; k < NW; k++) begin
            rdv(4'(8 + k), d, w);
            chk("R9 tail zero", d, 64'h0);
        end
        err_en = 0;

        // R12: error cleared by good fetch
        rdv(4'd8, d, w);
        chk("R12 error cleared", 64'(load_err), 64'h0);
        chk("R12 data restored", d, rev8(memval(word_of(2, 2, 0))));

        // R11: nonexistent block
        wr(4'd0, 64'h0000_0005_0000_0000);
        base_acc = acc_cnt;
        rdv(4'd8, d, w);
        chk("R11 read zero", d, 64'h0);
        chk("R11 error flag", 64'(load_err), 64'h1);
        chk("R11 no memory access", 64'(acc_cnt), 64'(base_acc));
        wr(4'd0, 64'h0000_0000_0000_0000);
        rdv(4'd8, d, w);
        chk("R12 clear after bad block", 64'(load_err), 64'h0);
        wr(4'd0, 64'h0000_0007_0000_0001);
        base_wr = wr_cnt;
        wr(4'd8, 64'hDEAD_BEEF_0000_0001);
        e = wr_cnt - base_wr;
        chk("R11 store blocked", 64'(e), 64'h0);
        chk("R11 store error", 64'(load_err), 64'h1);
        rdv(4'd8, d, w);
        chk("R11 read after blocked store", d, 64'h0);

        finish_run();
    end

endmodule